// File: doc/BRIEF.md
# Prefixed Opcode Fetch Sequencer

This block is the front end of an 8-bit processor's instruction fetch. It owns the program counter and the 7-bit memory refresh counter. It reads one byte per cycle from a combinational memory port at the current program counter. From those bytes it works out which opcode table the instruction belongs to. The recognised forms are:

- a plain opcode;
- one of the four single prefixes 0xCB, 0xDD, 0xED and 0xFD;
- the two indexed bit-operation forms 0xDD 0xCB and 0xFD 0xCB. In these forms a signed displacement byte sits between the prefix pair and the final opcode.

When a fetch is complete the block raises a one-cycle `done` strobe. With it come the table code, the final opcode byte, the displacement (raw and sign-extended) and a base cycle offset that the execution stage adds to its own count.

An index prefix can be followed directly by another index prefix. In that case the first one completes on its own as a NOP, reported as table 0 with opcode 0x00 and offset 4. The sequencer then restarts fetching at the second prefix without waiting for a new `start`. Executing the decoded instruction belongs to other blocks.

Top module: `pfx_fetch_seq`

## Requirements
- R1: After reset the program counter (`mem_addr`) is 0x0000, `refresh` is 0, and `done` and `busy` are low.
- R2: A first byte that is not 0xCB, 0xDD, 0xED or 0xFD completes the fetch with table code 0, `opcode` equal to that byte, `cyc_offset` 0, and the program counter advanced by 1.
- R3: A first byte of 0xCB, 0xDD, 0xED or 0xFD selects table code 1, 2, 3 or 4 respectively. When the following byte is not an index-bit-form continuation or a repeated index prefix, that byte is the opcode, `cyc_offset` is 4 and the program counter advances by 2. A 0xCB after 0xED, or any byte after 0xCB, is an ordinary opcode.
- R4: 0xDD followed by 0xCB gives table code 5, and 0xFD followed by 0xCB gives table code 6. The third byte is latched as the displacement and the fourth byte is the opcode. `cyc_offset` is 8 and the program counter advances by 4.
- R5: `disp_ext` is the 16-bit sign extension of `disp`: 0x80..0xFF map to 0xFF80..0xFFFF, and 0x00..0x7F map to 0x0000..0x007F.
- R6: 0xDD or 0xFD followed by 0xDD or 0xFD completes a NOP: table code 0, opcode 0x00, `cyc_offset` 4, and the program counter pointing at the second prefix, one past the first. Fetching then restarts by itself on the second prefix.
- R7: `refresh` increases by 1 on every first-byte fetch, including the restart after R6, and wraps from 127 to 0. Later bytes of the same fetch leave it unchanged.
- R8: Every byte read advances the program counter by one modulo 65536, so a fetch starting at 0xFFFF continues at 0x0000.
- R9: `done` is high for exactly one cycle per completed fetch. `busy` is high from the cycle after `start` until the fetch completes, and `start` is ignored while `busy` is high.
- R10: `pc_wr` loads `pc_wdata` into the program counter while idle and is ignored while busy.
- R11: `disp` and `disp_ext` read 0 on completions with table codes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch at the current program counter (idle only) |
| pc_wr | input | 1 | Load program counter (idle only) |
| pc_wdata | input | 16 | Value for the program counter load |
| mem_data | input | 8 | Byte at `mem_addr`, combinational |
| mem_rd | output | 1 | A byte is consumed this cycle |
| mem_addr | output | 16 | Current program counter |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle strobe: decode outputs valid |
| table_sel | output | 3 | 0 plain, 1 CB, 2 DD, 3 ED, 4 FD, 5 DD-CB, 6 FD-CB |
| opcode | output | 8 | Final opcode byte |
| disp | output | 8 | Raw displacement byte |
| disp_ext | output | 16 | Sign-extended displacement |
| cyc_offset | output | 4 | Base cycle offset (0, 4 or 8) |
| refresh | output | 7 | Refresh counter |

## Verification
Byte sequences for every table are run through one vector loop:

- A plain opcode and each single prefix show whether the first byte is classified correctly.
- Pairs such as 0xED 0xCB and 0xDD 0xED show that only an index prefix turns a following 0xCB into the indexed bit form.
- Displacements of 0x05, 0x7F, 0x80 and 0xF0 separate sign extension from zero extension and confirm that the byte before the opcode is taken as the displacement.

Directed runs then cover the following:

- a doubled index prefix, which must give a NOP and then a self-started second fetch;
- a fetch straddling address 0xFFFF;
- enough fetches to wrap the refresh counter;
- `start` and `pc_wr` pulsed in the middle of a four-byte fetch.

// File: rtl/pfx_fetch_seq.sv
module pfx_fetch_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 7,
  parameter int TW = 3,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pc_wr,
  input  logic [AW-1:0] pc_wdata,
  input  logic [DW-1:0] mem_data,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done,
  output logic [TW-1:0] table_sel,
  output logic [DW-1:0] opcode,
  output logic [DW-1:0] disp,
  output logic [AW-1:0] disp_ext,
  output logic [OW-1:0] cyc_offset,
  output logic [RW-1:0] refresh
);
  localparam logic [DW-1:0] B_CB = DW'(8'hCB);
  localparam logic [DW-1:0] B_DD = DW'(8'hDD);
  localparam logic [DW-1:0] B_ED = DW'(8'hED);
  localparam logic [DW-1:0] B_FD = DW'(8'hFD);
  localparam logic [TW-1:0] T_NONE = TW'(0);
  localparam logic [TW-1:0] T_CB = TW'(1);
  localparam logic [TW-1:0] T_DD = TW'(2);
  localparam logic [TW-1:0] T_ED = TW'(3);
  localparam logic [TW-1:0] T_FD = TW'(4);
  localparam logic [TW-1:0] T_DDCB = TW'(5);
  localparam logic [TW-1:0] T_FDCB = TW'(6);
  localparam logic [OW-1:0] OFF_PFX = OW'(4);
  localparam logic [OW-1:0] OFF_IDX = OW'(8);

  typedef enum logic [2:0] {S_IDLE, S_FIRST, S_SECOND, S_DISP, S_OP} st_t;

  st_t           st;
  logic [AW-1:0] pc;
  logic [TW-1:0] pend;
  logic [DW-1:0] disp_q;
  logic          idx_pend, idx_byte;

  assign idx_pend = (pend == T_DD) || (pend == T_FD);
  assign idx_byte = (mem_data == B_DD) || (mem_data == B_FD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pc         <= '0;
      refresh    <= '0;
      pend       <= T_NONE;
      disp_q     <= '0;
      done       <= 1'b0;
      table_sel  <= T_NONE;
      opcode     <= '0;
      disp       <= '0;
      cyc_offset <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pc_wr) pc <= pc_wdata;
          if (start) st <= S_FIRST;
        end
        S_FIRST: begin
          refresh <= refresh + RW'(1);
          pc      <= pc + AW'(1);
          if (mem_data == B_CB || mem_data == B_ED || idx_byte) begin
            st <= S_SECOND;
            case (mem_data)
              B_CB:    pend <= T_CB;
              B_DD:    pend <= T_DD;
              B_ED:    pend <= T_ED;
              default: pend <= T_FD;
            endcase
          end else begin
            done       <= 1'b1;
            table_sel  <= T_NONE;
            opcode     <= mem_data;
            disp       <= '0;
            cyc_offset <= '0;
            st         <= S_IDLE;
          end
        end
        S_SECOND: begin
          if (idx_pend && idx_byte) begin
            done       <= 1'b1;
            table_sel  <= T_NONE;
            opcode     <= '0;
            disp       <= '0;
            cyc_offset <= OFF_PFX;
            st         <= S_FIRST;
          end else if (idx_pend && mem_data == B_CB) begin
            pc   <= pc + AW'(1);
            pend <= (pend == T_DD) ? T_DDCB : T_FDCB;
            st   <= S_DISP;
          end else begin
            pc         <= pc + AW'(1);
            done       <= 1'b1;
            table_sel  <= pend;
            opcode     <= mem_data;
            disp       <= '0;
            cyc_offset <= OFF_PFX;
            st         <= S_IDLE;
          end
        end
        S_DISP: begin
          pc     <= pc + AW'(1);
          disp_q <= mem_data;
          st     <= S_OP;
        end
        default: begin
          pc         <= pc + AW'(1);
          done       <= 1'b1;
          table_sel  <= pend;
          opcode     <= mem_data;
          disp       <= disp_q;
          cyc_offset <= OFF_IDX;
          st         <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_addr = pc;
  assign mem_rd   = (st != S_IDLE);
  assign busy     = (st != S_IDLE);
  assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
endmodule

// File: rtl/pfx_fetch_seq_chk.sv
module pfx_fetch_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 7,
  parameter int TW = 3,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          pc_wr,
  input logic [AW-1:0] pc_wdata,
  input logic [DW-1:0] mem_data,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [TW-1:0] table_sel,
  input logic [DW-1:0] opcode,
  input logic [DW-1:0] disp,
  input logic [AW-1:0] disp_ext,
  input logic [OW-1:0] cyc_offset,
  input logic [RW-1:0] refresh
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_prefix_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && table_sel >= TW'(1) && table_sel <= TW'(4)) |-> cyc_offset == OW'(4));

  assert_index_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && table_sel >= TW'(5)) |-> cyc_offset == OW'(8));

  assert_refresh_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(refresh) |-> refresh == $past(refresh) + RW'(1));

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pc_wr) || $past(busy)) |->
      (mem_addr == $past(mem_addr) || mem_addr == $past(mem_addr) + AW'(1)));

  assert_disp_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && table_sel < TW'(5)) |-> disp == '0);
endmodule

bind pfx_fetch_seq pfx_fetch_seq_chk u_chk (.*);

// File: tb/pfx_fetch_seq_bench.sv
module pfx_fetch_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pc_wr = 1'b0;
  logic [15:0] pc_wdata = '0;
  logic [7:0]  mem_data;
  logic        mem_rd, busy, done;
  logic [15:0] mem_addr, disp_ext;
  logic [2:0]  table_sel;
  logic [7:0]  opcode, disp;
  logic [3:0]  cyc_offset;
  logic [6:0]  refresh;

  logic [7:0] mem [256];
  int n_chk = 0;
  int n_bad = 0;
  int r_exp = 0;

  always #10 clk = ~clk;
  assign mem_data = mem[mem_addr[7:0]];

  pfx_fetch_seq u_pfx_fetch_seq (.*);

  // b0 b1 b2 b3 | table | opcode | disp | offset | length
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {8'h3E, 8'h00, 8'h00, 8'h00, 8'd0, 8'h3E, 8'h00, 8'd0, 8'd1},
    {8'hCB, 8'h47, 8'h00, 8'h00, 8'd1, 8'h47, 8'h00, 8'd4, 8'd2},
    {8'hDD, 8'h21, 8'h00, 8'h00, 8'd2, 8'h21, 8'h00, 8'd4, 8'd2},
    {8'hED, 8'hB0, 8'h00, 8'h00, 8'd3, 8'hB0, 8'h00, 8'd4, 8'd2},
    {8'hFD, 8'hE5, 8'h00, 8'h00, 8'd4, 8'hE5, 8'h00, 8'd4, 8'd2},
    {8'hDD, 8'hCB, 8'h05, 8'h46, 8'd5, 8'h46, 8'h05, 8'd8, 8'd4},
    {8'hFD, 8'hCB, 8'hF0, 8'hC6, 8'd6, 8'hC6, 8'hF0, 8'd8, 8'd4},
    {8'hDD, 8'hCB, 8'h80, 8'h7E, 8'd5, 8'h7E, 8'h80, 8'd8, 8'd4},
    {8'hFD, 8'hCB, 8'h7F, 8'h56, 8'd6, 8'h56, 8'h7F, 8'd8, 8'd4},
    {8'hED, 8'hCB, 8'h00, 8'h00, 8'd3, 8'hCB, 8'h00, 8'd4, 8'd2},
    {8'hCB, 8'hDD, 8'h00, 8'h00, 8'd1, 8'hDD, 8'h00, 8'd4, 8'd2},
    {8'hDD, 8'hED, 8'h00, 8'h00, 8'd2, 8'hED, 8'h00, 8'd4, 8'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_pc(input logic [15:0] a);
    @(negedge clk);
    pc_wr = 1'b1;
    pc_wdata = a;
    @(negedge clk);
    pc_wr = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 20; i++) begin
      if (done) return;
      @(negedge clk);
    end
    chk(req, 32'hdead, 32'h1);
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] b0, b1, b2, b3);
    mem[a[7:0]]         = b0;
    mem[8'(a[7:0] + 1)] = b1;
    mem[8'(a[7:0] + 2)] = b2;
    mem[8'(a[7:0] + 3)] = b3;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [15:0] base;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(mem_addr), 32'h0);
    chk("R1 refresh", 32'(refresh), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      base = 16'h0010 + 16'(v * 8);
      put(base, VEC[v][71:64], VEC[v][63:56], VEC[v][55:48], VEC[v][47:40]);
      load_pc(base);
      kick();
      wait_done("R2 R3 R4 done");
      r_exp = (r_exp + 1) % 128;
      chk("R2 R3 R4 table", 32'(table_sel), 32'(VEC[v][39:32]));
      chk("R2 R3 R4 opcode", 32'(opcode), 32'(VEC[v][31:24]));
      chk("R4 R11 disp", 32'(disp), 32'(VEC[v][23:16]));
      chk("R5 disp_ext", 32'(disp_ext), 32'({{8{VEC[v][23]}}, VEC[v][23:16]}));
      chk("R2 R3 R4 offset", 32'(cyc_offset), 32'(VEC[v][15:8]));
      chk("R8 pc", 32'(mem_addr), 32'(base + 16'(VEC[v][7:0])));
      chk("R7 refresh", 32'(refresh), 32'(r_exp));
      @(negedge clk);
      chk("R9 done pulse", 32'(done), 32'h0);
      chk("R9 busy idle", 32'(busy), 32'h0);
    end

    // R6: doubled index prefix then indexed bit form on the second one
    base = 16'h00A0;
    put(base, 8'hDD, 8'hFD, 8'hCB, 8'h80);
    mem[8'hA4] = 8'h66;
    load_pc(base);
    kick();
    wait_done("R6 nop done");
    r_exp = (r_exp + 1) % 128;
    chk("R6 nop table", 32'(table_sel), 32'h0);
    chk("R6 nop opcode", 32'(opcode), 32'h0);
    chk("R6 nop offset", 32'(cyc_offset), 32'h4);
    chk("R6 nop pc", 32'(mem_addr), 32'h00A1);
    chk("R6 restart busy", 32'(busy), 32'h1);
    @(negedge clk);
    wait_done("R6 restart done");
    r_exp = (r_exp + 1) % 128;
    chk("R6 restart table", 32'(table_sel), 32'h6);
    chk("R6 restart opcode", 32'(opcode), 32'h66);
    chk("R5 negative disp_ext", 32'(disp_ext), 32'hFF80);
    chk("R6 restart pc", 32'(mem_addr), 32'h00A5);
    chk("R7 refresh twice", 32'(refresh), 32'(r_exp));

    // R8: wrap across 0xFFFF
    mem[8'hFF] = 8'hCB;
    mem[8'h00] = 8'h11;
    load_pc(16'hFFFF);
    kick();
    wait_done("R8 wrap done");
    r_exp = (r_exp + 1) % 128;
    chk("R8 wrap table", 32'(table_sel), 32'h1);
    chk("R8 wrap opcode", 32'(opcode), 32'h11);
    chk("R8 wrap pc", 32'(mem_addr), 32'h0001);

    // R9 R10: start and pc_wr pulsed mid-fetch are ignored
    base = 16'h00C0;
    put(base, 8'hDD, 8'hCB, 8'h10, 8'h4E);
    load_pc(base);
    kick();
    start = 1'b1;
    pc_wr = 1'b1;
    pc_wdata = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    pc_wr = 1'b0;
    wait_done("R9 busy done");
    r_exp = (r_exp + 1) % 128;
    chk("R10 pc_wr ignored", 32'(mem_addr), 32'h00C4);
    chk("R9 opcode", 32'(opcode), 32'h4E);
    chk("R5 positive disp_ext", 32'(disp_ext), 32'h0010);
    repeat (3) begin
      @(negedge clk);
      chk("R9 start ignored busy", 32'(busy), 32'h0);
      chk("R9 start ignored done", 32'(done), 32'h0);
    end
    chk("R7 refresh after busy start", 32'(refresh), 32'(r_exp));

    // R7: refresh wraps from 127 to 0
    mem[8'hE0] = 8'h00;
    for (int k = 0; k < 130; k++) begin
      load_pc(16'h00E0);
      kick();
      wait_done("R7 loop done");
      r_exp = (r_exp + 1) % 128;
    end
    chk("R7 refresh wrap", 32'(refresh), 32'(r_exp));
    chk("R2 plain zero opcode", 32'(opcode), 32'h0);
    chk("R2 plain offset", 32'(cyc_offset), 32'h0);

    summary();
  end
endmodule